// File: doc/BRIEF.md
# Two-Client Four-Phase Mutual Exclusion Arbiter

This block lets two clients, called left and right, share one resource. Only one of them can hold it at a time. Each client has a request input and a grant output. The pair runs a return-to-zero handshake in four steps:

1. The client raises its request.
2. The arbiter raises the grant.
3. The client withdraws the request.
4. The arbiter lowers the grant.

A grant stays high for as long as its request stays high. The grant falls on the first clock edge that samples the request low.

Both grants are registered and change on the rising clock edge. Reset is synchronous and active high.

When both clients ask at once and neither holds the resource, a fixed tie-break picks the winner. The default winner is the left client. A client that was already waiting while the other held the grant is preferred over a client whose request is new. This means a waiting client gets the resource on the edge after the other grant falls.

Each side has a handshake monitor. It watches for a client that changes its request while that request still differs from its grant. Examples are withdrawing before being granted, or asking again before the grant has fallen. Any such event sets a sticky error flag.

Top module: `arb_mutex2`

## Requirements
- R1: While reset is high and on the first cycle after it, `gnt_left`, `gnt_right` and `protocol_error` are 0.
- R2: A grant rises on the edge that samples its request high while both grants are low, unless the other client wins the tie (R6, R7).
- R3: A grant that is high stays high on every edge that samples its request still high.
- R4: A high grant falls on the first edge that samples its request low.
- R5: `gnt_left` and `gnt_right` are never both 1 in the same cycle.
- R6: When both requests are sampled high on the same edge, both grants are low, and neither request was pending on the previous edge, the left client is granted. This holds with the default `PREFER_RIGHT = 0`.
- R7: A client whose request was pending while the other held the grant is granted on the edge after that grant falls. This holds even if the other client raises its request again at once.
- R8: Whenever a grant changes value, its new value equals its own request as sampled on the previous edge.
- R9: `protocol_error` goes to 1 on the edge that samples a client's request differing from its previous sample while that previous sample differs from the grant then shown. An example is dropping a request that is still pending.
- R10: Once set, `protocol_error` stays 1 until reset. Legal four-phase traffic never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_left | input | 1 | Left client request |
| req_right | input | 1 | Right client request |
| gnt_left | output | 1 | Left client grant (registered) |
| gnt_right | output | 1 | Right client grant (registered) |
| protocol_error | output | 1 | Sticky flag for a client handshake violation |

## Verification
The bench runs each client alone through a full handshake. It holds the request for several cycles to separate holding the grant (R3) from regranting it.

Simultaneous new requests expose the tie-break (R6). A handoff in which the previous owner asks again right after its grant falls separates the waiting-client preference (R7) from a plain fixed priority.

Long stretches of random legal traffic on both sides exercise exclusion (R5) and must leave the error flag clear (R10). A pending request that is withdrawn early must set that flag and keep it set.

// File: rtl/arb_pkg.sv
package arb_pkg;

   localparam int unsigned NUM_SIDES = 2;

   // A client may only move its request while the request it last showed
   // matches the grant it currently sees.
   function automatic logic hs_violation(input logic req_now,
                                         input logic req_prev,
                                         input logic gnt_seen);
      return (req_now != req_prev) && (req_prev != gnt_seen);
   endfunction

endpackage

// File: rtl/arb_hs_monitor.sv
module arb_hs_monitor
   import arb_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic req,
   input  logic gnt,
   output logic err
);

   logic req_q;
   logic err_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         req_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         req_q <= req;
         err_q <= err_q | hs_violation(req, req_q, gnt);
      end
   end

   assign err = err_q;

   // R10: the flag never clears outside reset
   p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
      err_q |=> err_q);

endmodule

// File: rtl/arb_grant_core.sv
module arb_grant_core #(
   parameter bit PREFER_RIGHT = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic req_l,
   input  logic req_r,
   output logic gnt_l,
   output logic gnt_r
);

   logic gl_q, gr_q;
   logic rl_q, rr_q;
   logic pend_l, pend_r;
   logic tie_left;
   logic left_wins;
   logic gl_n, gr_n;

   // a request seen on the last edge that is still ungranted counts as waiting
   assign pend_l = rl_q & ~gl_q;
   assign pend_r = rr_q & ~gr_q;

   generate
      if (PREFER_RIGHT) begin : g_tie_right
         assign tie_left = 1'b0;
      end else begin : g_tie_left
         assign tie_left = 1'b1;
      end
   endgenerate

   always_comb begin
      if (pend_l && !pend_r)      left_wins = 1'b1;
      else if (pend_r && !pend_l) left_wins = 1'b0;
      else                        left_wins = tie_left;
   end

   always_comb begin
      gl_n = gl_q ? req_l : (req_l & ~gr_q & (~req_r | left_wins));
      gr_n = gr_q ? req_r : (req_r & ~gl_q & (~req_l | ~left_wins));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         gl_q <= 1'b0;
         gr_q <= 1'b0;
         rl_q <= 1'b0;
         rr_q <= 1'b0;
      end else begin
         gl_q <= gl_n;
         gr_q <= gr_n;
         rl_q <= req_l;
         rr_q <= req_r;
      end
   end

   assign gnt_l = gl_q;
   assign gnt_r = gr_q;

   p_mutex_r5: assert property (@(posedge clk) disable iff (rst)
      !(gl_q && gr_q));
   p_hold_left_r3: assert property (@(posedge clk) disable iff (rst)
      (gl_q && req_l) |=> gl_q);
   p_hold_right_r3: assert property (@(posedge clk) disable iff (rst)
      (gr_q && req_r) |=> gr_q);
   p_rise_left_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(gl_q) |-> !$past(gr_q));
   p_rise_right_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(gr_q) |-> !$past(gl_q));
   p_change_left_r8: assert property (@(posedge clk) disable iff (rst)
      (gl_q != $past(gl_q)) |-> (gl_q == $past(req_l)));
   p_change_right_r8: assert property (@(posedge clk) disable iff (rst)
      (gr_q != $past(gr_q)) |-> (gr_q == $past(req_r)));

endmodule

// File: rtl/arb_mutex2.sv
module arb_mutex2
   import arb_pkg::*;
#(
   parameter bit PREFER_RIGHT = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic req_left,
   input  logic req_right,
   output logic gnt_left,
   output logic gnt_right,
   output logic protocol_error
);

   initial begin
      if (NUM_SIDES != 2) $error("arb_mutex2 supports exactly two sides");
   end

   logic [NUM_SIDES-1:0] req_v;
   logic [NUM_SIDES-1:0] gnt_v;
   logic [NUM_SIDES-1:0] err_v;

   assign req_v = {req_right, req_left};
   assign gnt_v = {gnt_right, gnt_left};

   arb_grant_core #(.PREFER_RIGHT(PREFER_RIGHT)) u_core (
      .clk   (clk),
      .rst   (rst),
      .req_l (req_left),
      .req_r (req_right),
      .gnt_l (gnt_left),
      .gnt_r (gnt_right)
   );

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_mon
      arb_hs_monitor u_mon (
         .clk (clk),
         .rst (rst),
         .req (req_v[s]),
         .gnt (gnt_v[s]),
         .err (err_v[s])
      );
   end

   assign protocol_error = |err_v;

   // R5: checked at the block boundary as well
   p_out_mutex_r5: assert property (@(posedge clk) disable iff (rst)
      $countones(gnt_v) <= 1);

endmodule

// File: tb/sim_arb_mutex2.sv
`timescale 1ns/1ps
module sim_arb_mutex2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic req_l = 1'b0, req_r = 1'b0;
   logic gnt_l, gnt_r, perr;
   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   arb_mutex2 u0 (
      .clk(clk), .rst(rst), .req_left(req_l), .req_right(req_r),
      .gnt_left(gnt_l), .gnt_right(gnt_r), .protocol_error(perr)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic drive(input logic l, input logic r);
      @(negedge clk);
      req_l = l; req_r = r;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; req_l = 1'b0; req_r = 1'b0;
      step(); step();
      check("R1 reset gl", gnt_l, 0);
      check("R1 reset gr", gnt_r, 0);
      check("R1 reset err", perr, 0);
      @(negedge clk); rst = 1'b0;
      step();
      check("R1 post gl", gnt_l, 0);
      check("R1 post gr", gnt_r, 0);
   endtask

   task automatic t_solo_left();
      drive(1, 0); step();
      check("R2 left granted", gnt_l, 1);
      for (int i = 0; i < 4; i++) begin
         drive(1, 0); step();
         check("R3 left held", gnt_l, 1);
      end
      drive(0, 0); step();
      check("R4 left dropped", gnt_l, 0);
      check("R10 legal no err", perr, 0);
   endtask

   task automatic t_solo_right();
      drive(0, 1); step();
      check("R2 right granted", gnt_r, 1);
      check("R5 left off", gnt_l, 0);
      drive(0, 1); step();
      check("R3 right held", gnt_r, 1);
      drive(0, 0); step();
      check("R4 right dropped", gnt_r, 0);
   endtask

   task automatic t_tie_handoff();
      drive(1, 1); step();
      check("R6 tie left", gnt_l, 1);
      check("R6 tie right waits", gnt_r, 0);
      drive(1, 1); step();
      check("R5 right still waits", gnt_r, 0);
      drive(0, 1); step();
      check("R4 left falls", gnt_l, 0);
      check("R8 right not yet", gnt_r, 0);
      drive(1, 1); step();   // left asks again at once
      check("R7 waiting right wins", gnt_r, 1);
      check("R7 left held off", gnt_l, 0);
      drive(1, 0); step();
      check("R4 right falls", gnt_r, 0);
      drive(1, 0); step();
      check("R7 left after right", gnt_l, 1);
      drive(0, 0); step();
      check("R10 tie traffic legal", perr, 0);
   endtask

   task automatic t_random_legal();
      logic pl, pr, pgl, pgr;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if (req_l == gnt_l && ($urandom % 3 == 0)) req_l = ~req_l;
         if (req_r == gnt_r && ($urandom % 3 == 0)) req_r = ~req_r;
         pl = req_l; pr = req_r; pgl = gnt_l; pgr = gnt_r;
         step();
         if (gnt_l && gnt_r) check("R5 random mutex", 1, 0);
         if (pgl && pl) check("R3 random hold left", gnt_l, 1);
         if (pgr && pr) check("R3 random hold right", gnt_r, 1);
         if (pgl && !pl) check("R4 random drop left", gnt_l, 0);
         if (pgr && !pr) check("R4 random drop right", gnt_r, 0);
      end
      check("R10 random legal no err", perr, 0);
      drive(0, 0); step(); step(); step();
   endtask

   task automatic t_illegal_drop();
      drive(0, 1); step();
      check("R2 right owns", gnt_r, 1);
      drive(1, 1); step();
      check("R9 no err while waiting", perr, 0);
      drive(0, 1); step();   // pending left request withdrawn
      check("R9 err raised", perr, 1);
      for (int i = 0; i < 3; i++) begin
         drive(0, 0); step();
         check("R10 err sticky", perr, 1);
      end
      do_reset();
      check("R10 err cleared by reset", perr, 0);
   endtask

   initial begin
      do_reset();
      t_solo_left();
      t_solo_right();
      t_tie_handoff();
      t_random_legal();
      t_illegal_drop();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule